// File: doc/BRIEF.md
# Iterative AES-256 Block Encryption Engine

This block encrypts one 128-bit plaintext block under AES-256 over many clock cycles. It holds one pass of round hardware and reuses it. A control state machine steps through the cipher phases one per cycle: round-key addition, byte substitution, row rotation and column mixing. Each phase writes its own 4x4 byte matrix register, and only the next phase reads that register. The round keys come from a separate key-expansion unit. The engine asks that unit to start, waits for its done level, and then reads the keys one at a time through an index/data port pair.

A user drives a plaintext block together with a one-cycle `start` while the engine is idle. The engine then raises `ks_start`, waits for `ks_done`, and runs the initial key addition followed by `NR` rounds. At the end it shows the ciphertext with a one-cycle `valid`. The ciphertext then stays on its port until the next accepted request rewrites it.

Top module: `aes256_round_engine`

## Requirements
- R1: While `rst_n` is low at a clock edge, the engine returns to idle with `valid` low, `ks_start` low, `rk_index` 0 and `ciphertext` all zero.
- R2: A `start` sampled high while idle is accepted, and `ks_start` is high for exactly one cycle: the cycle right after that edge.
- R3: No key addition happens while `ks_done` is low. With `ks_done` already high, `valid` is seen 4*NR+2 clock edges after the start edge, counting the start edge as 1. Each extra edge at which `ks_done` is still low delays `valid` by one edge.
- R4: Byte i of any 128-bit port is bits [127-8i -: 8]. It sits at row i mod 4, column i div 4 of the 4x4 matrix. This holds for plaintext, round keys and ciphertext.
- R5: The result is AES-256 encryption. The steps are: an initial round-key addition, then NR rounds of S-box, row rotation (row r rotated left by r bytes), column mixing with [2 3 1 1; 1 2 3 1; 1 1 2 3; 3 1 1 2] over GF(2^8) mod 0x11B, and key addition. The last round leaves out the mixing. Key 97247d91d32fa1f6bece5da9bfe61c1a3b32edf26fd6ec2a6187ba777fc3c1d8 with plaintext e536638ecbcec0be6ce6a97e98da827b gives 6034088a2dedde69013d073e8681d21c.
- R6: Key 000102...1f with plaintext 00112233445566778899aabbccddeeff gives 8ea2b7ca516745bfeafc49904b496089.
- R7: `valid` is high for exactly one cycle per accepted request.
- R8: A `start` that arrives while a request is in progress is ignored. This includes the cycle in which `valid` is high. Such a `start` changes neither the result nor the timing, and produces no `ks_start`.
- R9: `rk_index` is 0 during the initial key addition and r during round r. It changes only by stepping up by one or by returning to 0, and it reads NR when `valid` is high.
- R10: After `valid`, `ciphertext` holds its value until a new request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request pulse, accepted only when idle |
| plaintext | input | 128 | Block to encrypt, sampled at the accepted start edge |
| ks_start | output | 1 | One-cycle request to the key-expansion unit |
| ks_done | input | 1 | Level from the key-expansion unit: round keys are readable |
| rk_index | output | $clog2(NR+1) | Number of the round key being read |
| rk_data | input | 128 | Round key selected by `rk_index`, same byte order as plaintext |
| ciphertext | output | 128 | Encrypted block |
| valid | output | 1 | One-cycle flag: ciphertext is ready |

## Verification
The bench builds the engine with its default NR = 14, which is AES-256. At that value both published 256-bit vectors and an independent reference model can be checked bit for bit. The same setting makes the 58-edge run length and the index sweep 0..14 exact numbers for the bench to compare against. The bench also plays the key-expansion unit itself, so it can keep `ks_done` low for a chosen number of cycles. Because it controls when `start` is raised, it can also raise `start` mid-run and during the `valid` cycle.

// File: rtl/aes_eng_pkg.sv
// Package: shared types and GF(2^8) helpers for the iterative AES engine.
// Assumes byte 0 of a block is its most significant byte and the matrix
// is filled column by column.
package aes_eng_pkg;

    localparam int MAT_DIM  = 4;
    localparam int BYTE_W   = 8;
    localparam int BLK_BITS = MAT_DIM * MAT_DIM * BYTE_W;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef byte_t [MAT_DIM-1:0][MAT_DIM-1:0] mat_t;   // [row][col]

    typedef enum logic [2:0] {
        PH_IDLE, PH_KWAIT, PH_ARK, PH_SUB, PH_SHIFT, PH_MIX, PH_FIN
    } phase_t;

    // Multiply by x modulo 0x11B.
    function automatic byte_t gf_x2(input byte_t a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1B : 8'h00);
    endfunction

    // General product in GF(2^8).
    function automatic byte_t gf_mul(input byte_t a, input byte_t b);
        byte_t acc = '0;
        byte_t sh  = a;
        for (int i = 0; i < BYTE_W; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = gf_x2(sh);
        end
        return acc;
    endfunction

    // S-box: inverse as x^254 by a squaring chain, then the affine map.
    function automatic byte_t sbox_calc(input byte_t x);
        byte_t sq  = x;
        byte_t inv = 8'h01;
        for (int k = 1; k < BYTE_W; k++) begin
            sq  = gf_mul(sq, sq);
            inv = gf_mul(inv, sq);
        end
        return inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]}
                   ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
    endfunction

    // Bus to matrix, column-major, byte 0 in the top bits.
    function automatic mat_t blk_to_mat(input logic [BLK_BITS-1:0] b);
        mat_t m;
        for (int i = 0; i < MAT_DIM * MAT_DIM; i++)
            m[i % MAT_DIM][i / MAT_DIM] = b[BLK_BITS-1-BYTE_W*i -: BYTE_W];
        return m;
    endfunction

    // Matrix to bus, inverse of blk_to_mat.
    function automatic logic [BLK_BITS-1:0] mat_to_blk(input mat_t m);
        logic [BLK_BITS-1:0] b;
        for (int i = 0; i < MAT_DIM * MAT_DIM; i++)
            b[BLK_BITS-1-BYTE_W*i -: BYTE_W] = m[i % MAT_DIM][i / MAT_DIM];
        return b;
    endfunction

endpackage

// File: rtl/aes_sub_bytes.sv
// Module: substitutes every byte of a matrix through the S-box in one
// cycle of combinational logic. Assumes a square matrix of MAT_DIM.
module aes_sub_bytes
    import aes_eng_pkg::*;
(
    input  mat_t din,
    output mat_t dout
);
    for (genvar r = 0; r < MAT_DIM; r++) begin : g_row
        for (genvar c = 0; c < MAT_DIM; c++) begin : g_col
            // One S-box per byte position.
            assign dout[r][c] = sbox_calc(din[r][c]);
        end
    end
endmodule

// File: rtl/aes_mix_column.sv
// Module: mixes one four-byte column with the fixed circulant
// [2 3 1 1] over GF(2^8). Purely combinational.
module aes_mix_column
    import aes_eng_pkg::*;
(
    input  byte_t [MAT_DIM-1:0] col_in,
    output byte_t [MAT_DIM-1:0] col_out
);
    for (genvar r = 0; r < MAT_DIM; r++) begin : g_out
        localparam int R1 = (r + 1) % MAT_DIM;
        localparam int R2 = (r + 2) % MAT_DIM;
        localparam int R3 = (r + 3) % MAT_DIM;
        // Output row r: 2*a[r] ^ 3*a[r+1] ^ a[r+2] ^ a[r+3].
        assign col_out[r] = gf_x2(col_in[r]) ^ gf_x2(col_in[R1]) ^ col_in[R1]
                          ^ col_in[R2] ^ col_in[R3];
    end
endmodule

// File: rtl/aes_round_ctrl.sv
// Module: phase sequencer. Accepts a request only when idle, starts the key
// unit, waits for its done level, then walks the initial key addition and
// NR rounds, the last one without column mixing.
module aes_round_ctrl
    import aes_eng_pkg::*;
#(
    parameter int NR    = 14,
    parameter int IDX_W = $clog2(NR + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             ks_done,
    output phase_t           phase,
    output logic [IDX_W-1:0] round,
    output logic             ks_start,
    output logic             valid
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NR);

    // Phase, round counter and key-unit request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            round    <= '0;
            ks_start <= 1'b0;
        end else begin
            ks_start <= 1'b0;
            case (phase)
                PH_IDLE: if (start) begin
                    phase    <= PH_KWAIT;
                    ks_start <= 1'b1;
                end
                PH_KWAIT: if (ks_done) begin
                    phase <= PH_ARK;
                    round <= '0;
                end
                PH_ARK: begin
                    if (round == LAST) begin
                        phase <= PH_FIN;
                    end else begin
                        phase <= PH_SUB;
                        round <= round + 1'b1;
                    end
                end
                PH_SUB:   phase <= PH_SHIFT;
                PH_SHIFT: phase <= (round == LAST) ? PH_ARK : PH_MIX;
                PH_MIX:   phase <= PH_ARK;
                default:  phase <= PH_IDLE;
            endcase
        end
    end

    // Result flag lasts the single FIN cycle.
    assign valid = (phase == PH_FIN);
endmodule

// File: rtl/aes256_round_engine.sv
// Module: top of the iterative AES engine. Each transform owns one 4x4
// byte matrix register, written by one process and read by the next.
// Assumes rk_data follows rk_index in the same cycle.
module aes256_round_engine
    import aes_eng_pkg::*;
#(
    parameter int NR = 14,
    localparam int RK_IDX_W = $clog2(NR + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [127:0]        plaintext,
    output logic                ks_start,
    input  logic                ks_done,
    output logic [RK_IDX_W-1:0] rk_index,
    input  logic [127:0]        rk_data,
    output logic [127:0]        ciphertext,
    output logic                valid
);
    localparam logic [RK_IDX_W-1:0] LAST = RK_IDX_W'(NR);

    phase_t              phase;
    logic [RK_IDX_W-1:0] round;
    mat_t init_m, ark_m, sub_m, shift_m, mix_m;
    mat_t ark_src, sub_w, shift_w, mix_w;

    aes_round_ctrl #(.NR(NR), .IDX_W(RK_IDX_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .ks_done(ks_done),
        .phase(phase), .round(round), .ks_start(ks_start), .valid(valid)
    );

    aes_sub_bytes u_sub (.din(ark_m), .dout(sub_w));

    for (genvar r = 0; r < MAT_DIM; r++) begin : g_shift_row
        for (genvar c = 0; c < MAT_DIM; c++) begin : g_shift_col
            // Row r rotated left by r positions.
            assign shift_w[r][c] = sub_m[r][(c + r) % MAT_DIM];
        end
    end

    for (genvar c = 0; c < MAT_DIM; c++) begin : g_mix
        byte_t [MAT_DIM-1:0] col_i, col_o;
        for (genvar r = 0; r < MAT_DIM; r++) begin : g_tap
            assign col_i[r]    = shift_m[r][c];
            assign mix_w[r][c] = col_o[r];
        end
        aes_mix_column u_col (.col_in(col_i), .col_out(col_o));
    end

    // Source of the key addition: loaded block, mixed state, or unmixed state.
    always_comb begin
        if (round == '0)        ark_src = init_m;
        else if (round == LAST) ark_src = shift_m;
        else                    ark_src = mix_m;
    end

    // Initial matrix: captured on an accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) init_m <= '0;
        else if (phase == PH_IDLE && start) init_m <= blk_to_mat(plaintext);
    end

    // Round-key matrix: written in the key-addition phase only.
    always_ff @(posedge clk) begin
        if (!rst_n) ark_m <= '0;
        else if (phase == PH_ARK) ark_m <= ark_src ^ blk_to_mat(rk_data);
    end

    // Substitution matrix.
    always_ff @(posedge clk) begin
        if (!rst_n) sub_m <= '0;
        else if (phase == PH_SUB) sub_m <= sub_w;
    end

    // Row-shift matrix.
    always_ff @(posedge clk) begin
        if (!rst_n) shift_m <= '0;
        else if (phase == PH_SHIFT) shift_m <= shift_w;
    end

    // Column-mix matrix.
    always_ff @(posedge clk) begin
        if (!rst_n) mix_m <= '0;
        else if (phase == PH_MIX) mix_m <= mix_w;
    end

    assign rk_index   = round;
    assign ciphertext = mat_to_blk(ark_m);
endmodule

// File: rtl/aes256_round_engine_chk.sv
// Module: protocol checker for the AES engine, bound to its top.
// Assumes reset is held low from time zero for at least one edge.
module aes256_round_engine_chk #(
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             ks_start,
    input logic             valid,
    input logic [IDX_W-1:0] rk_index,
    input logic [127:0]     ciphertext
);
    logic busy_q;
    logic hold_q;

    // Tracks a run: from key request to result flag.
    always_ff @(posedge clk) begin
        if (!rst_n)        busy_q <= 1'b0;
        else if (valid)    busy_q <= 1'b0;
        else if (ks_start) busy_q <= 1'b1;
    end

    // Tracks the hold window: from result flag to next key request.
    always_ff @(posedge clk) begin
        if (!rst_n)        hold_q <= 1'b0;
        else if (ks_start) hold_q <= 1'b0;
        else if (valid)    hold_q <= 1'b1;
    end

    a_r7_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

    a_r2_ks_start_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        ks_start |=> !ks_start);

    a_r2_ks_start_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ks_start) |-> $past(start));

    a_r8_no_restart_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> !ks_start);

    a_r9_index_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (rk_index != $past(rk_index)) |->
            (rk_index == $past(rk_index) + 1'b1 || rk_index == '0));

    a_r10_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
        hold_q |-> $stable(ciphertext));
endmodule

bind aes256_round_engine aes256_round_engine_chk #(.IDX_W(RK_IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .ks_start(ks_start),
    .valid(valid), .rk_index(rk_index), .ciphertext(ciphertext)
);

// File: tb/test_aes256_round_engine.sv
// Directed bench: acts as the key-expansion unit, drives requests, and
// compares against published vectors and an independent reference model.
module test_aes256_round_engine;
    localparam int NR    = 14;
    localparam int IDX_W = $clog2(NR + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [127:0]     plaintext = '0;
    logic             ks_start;
    logic             ks_done = 1'b0;
    logic [IDX_W-1:0] rk_index;
    logic [127:0]     rk_data;
    logic [127:0]     ciphertext;
    logic             valid;

    logic [127:0] rk_tbl [0:15];
    logic [7:0]   sb [0:255];
    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;   // 125 MHz

    assign rk_data = rk_tbl[rk_index];

    aes256_round_engine #(.NR(NR)) i_aes256_round_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .plaintext(plaintext),
        .ks_start(ks_start), .ks_done(ks_done), .rk_index(rk_index),
        .rk_data(rk_data), .ciphertext(ciphertext), .valid(valid)
    );

    // ---------------- reference model ----------------
    function automatic logic [7:0] xt(input logic [7:0] a);
        return a[7] ? ((a << 1) ^ 8'h1B) : (a << 1);
    endfunction

    function automatic logic [7:0] gm(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] p = 0;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) p ^= a;
            a = xt(a);
        end
        return p;
    endfunction

    // S-box built by searching inverses, then the affine map.
    task automatic build_sbox();
        for (int x = 0; x < 256; x++) begin
            logic [7:0] inv = 0;
            logic [7:0] v;
            for (int y = 1; y < 256; y++)
                if (x != 0 && gm(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
            v = 8'h63;
            for (int k = 0; k < 5; k++) v ^= 8'((inv << k) | (inv >> (8 - k)));
            sb[x] = v;
        end
    endtask

    function automatic logic [7:0] gb(input logic [127:0] v, input int i);
        return v[127-8*i -: 8];
    endfunction

    function automatic logic [31:0] subw(input logic [31:0] w);
        return {sb[w[31:24]], sb[w[23:16]], sb[w[15:8]], sb[w[7:0]]};
    endfunction

    // Plays the key-expansion unit: fills the round-key table.
    task automatic load_key(input logic [255:0] key);
        logic [31:0] w [0:59];
        logic [31:0] t;
        logic [7:0]  rc = 8'h01;
        for (int i = 0; i < 8; i++) w[i] = key[255-32*i -: 32];
        for (int i = 8; i < 60; i++) begin
            t = w[i-1];
            if (i % 8 == 0) begin
                t  = subw({t[23:0], t[31:24]}) ^ {rc, 24'h0};
                rc = xt(rc);
            end else if (i % 8 == 4) begin
                t = subw(t);
            end
            w[i] = w[i-8] ^ t;
        end
        for (int r = 0; r <= NR; r++) rk_tbl[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
        rk_tbl[15] = '0;
    endtask

    function automatic logic [127:0] ref_enc(input logic [127:0] pt);
        logic [127:0] s = pt ^ rk_tbl[0];
        logic [127:0] o;
        for (int r = 1; r <= NR; r++) begin
            for (int i = 0; i < 16; i++) s[127-8*i -: 8] = sb[gb(s, i)];
            for (int row = 0; row < 4; row++)
                for (int c = 0; c < 4; c++)
                    o[127-8*(row+4*c) -: 8] = gb(s, row + 4*((c + row) % 4));
            s = o;
            if (r < NR) begin
                for (int c = 0; c < 4; c++) begin
                    logic [7:0] a0 = gb(s, 4*c), a1 = gb(s, 4*c+1);
                    logic [7:0] a2 = gb(s, 4*c+2), a3 = gb(s, 4*c+3);
                    o[127-8*(4*c)   -: 8] = gm(a0,2) ^ gm(a1,3) ^ a2 ^ a3;
                    o[127-8*(4*c+1) -: 8] = a0 ^ gm(a1,2) ^ gm(a2,3) ^ a3;
                    o[127-8*(4*c+2) -: 8] = a0 ^ a1 ^ gm(a2,2) ^ gm(a3,3);
                    o[127-8*(4*c+3) -: 8] = gm(a0,3) ^ a1 ^ a2 ^ gm(a3,2);
                end
                s = o;
            end
            s ^= rk_tbl[r];
        end
        return s;
    endfunction

    // ---------------- checking helpers ----------------
    task automatic chk(input bit ok, input string req,
                       input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One request with full protocol checks.
    task automatic run_and_check(input string tag, input logic [127:0] pt,
                                 input logic [127:0] exp, input int kwait,
                                 input int busy_at, input bit fin_poke);
        int n = 0, lat = 0, exp_lat;
        logic ks1 = 0, ks2 = 0, quiet = 1;
        logic [IDX_W-1:0] rk0 = '1, rkfin = '0;
        logic [127:0] ctv = '0;
        exp_lat = 4*NR + 2 + ((kwait > 1) ? kwait - 1 : 0);
        ks_done = (kwait == 0);
        @(negedge clk);
        plaintext = pt;
        start = 1'b1;
        while (lat == 0 && n < 1000) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            start = 1'b0;
            if (n == 1) ks1 = ks_start;
            if (n == 2) ks2 = ks_start;
            if (n == kwait) ks_done = 1'b1;
            if (n == 2 + ((kwait > 1) ? kwait - 1 : 0)) rk0 = rk_index;
            if (n == busy_at) begin start = 1'b1; plaintext = ~pt; end
            if (valid) begin
                lat = n; rkfin = rk_index; ctv = ciphertext;
                if (fin_poke) begin start = 1'b1; plaintext = ~pt; end
            end
        end
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        chk(valid == 1'b0, {tag, " R7 valid single cycle"}, 128'(valid), 128'(0));
        for (int k = 0; k < 4; k++) begin
            if (valid || ks_start || ciphertext != ctv) quiet = 0;
            @(negedge clk);
        end
        chk(ks1 == 1'b1 && ks2 == 1'b0, {tag, " R2 ks_start pulse"}, 128'({ks1, ks2}), 128'(2'b10));
        chk(lat == exp_lat, {tag, " R3 latency"}, 128'(lat), 128'(exp_lat));
        chk(ctv == exp, {tag, " R5 ciphertext"}, ctv, exp);
        chk(rk0 == '0 && rkfin == IDX_W'(NR), {tag, " R9 key index"},
            128'({rk0, rkfin}), 128'({IDX_W'(0), IDX_W'(NR)}));
        chk(quiet == 1'b1, {tag, " R10 R8 result held, no restart"}, 128'(quiet), 128'(1));
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(valid == 0 && ks_start == 0, "R1 flags in reset", 128'({valid, ks_start}), 128'(0));
        chk(ciphertext == '0, "R1 ciphertext in reset", ciphertext, '0);
        chk(rk_index == '0, "R1 rk_index in reset", 128'(rk_index), 128'(0));
        rst_n = 1'b1;
    endtask

    task automatic t_doc_vector();
        load_key(256'h97247d91d32fa1f6bece5da9bfe61c1a3b32edf26fd6ec2a6187ba777fc3c1d8);
        run_and_check("R5 vector", 128'he536638ecbcec0be6ce6a97e98da827b,
                      128'h6034088a2dedde69013d073e8681d21c, 0, 0, 0);
    endtask

    task automatic t_std_vector();
        load_key(256'h000102030405060708090a0b0c0d0e0f101112131415161718191a1b1c1d1e1f);
        run_and_check("R6 vector", 128'h00112233445566778899aabbccddeeff,
                      128'h8ea2b7ca516745bfeafc49904b496089, 0, 0, 0);
    endtask

    task automatic t_model_vectors();
        logic [127:0] pt;
        load_key('0);
        run_and_check("R4 zero", '0, ref_enc('0), 0, 0, 0);
        load_key({8{32'h0f1e2d3c}});
        pt = 128'h80000000_00000000_00000000_00000001;
        run_and_check("R4 sparse", pt, ref_enc(pt), 0, 0, 0);
    endtask

    task automatic t_key_wait();
        logic [127:0] pt = 128'hfedcba98_76543210_01234567_89abcdef;
        load_key({4{64'hdeadbeef_a5a55a5a}});
        run_and_check("R3 key wait", pt, ref_enc(pt), 20, 0, 0);
    endtask

    task automatic t_busy_start();
        logic [127:0] pt = 128'h3243f6a8_885a308d_313198a2_e0370734;
        load_key(256'h2b7e1516_28aed2a6_abf71588_09cf4f3c_00112233_44556677_8899aabb_ccddeeff);
        run_and_check("R8 busy start", pt, ref_enc(pt), 0, 15, 1);
    endtask

    // Watchdog: a hung run is a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        build_sbox();
        for (int i = 0; i < 16; i++) rk_tbl[i] = '0;
        t_reset();
        t_doc_vector();
        t_std_vector();
        t_model_vectors();
        t_key_wait();
        t_busy_start();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule